// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter for a small controller. Software sets it up through a control register and keeps it alive by writing a command byte to a second register. If the count is allowed to reach the programmed detection time, the block raises either a one-clock interrupt request or a reset request of fixed length. Which of the two it raises depends on the output-select setting.

Both registers are write-only. Reads return nothing defined, and no read path exists. The count advances on a tick input supplied by the clock prescaler. A mode input chooses which of two detection-time tables applies: the fast timebase or the slow timebase. A synthesis parameter `SHIFT` divides every detection time by the same power of two.

The block is protected in two ways:
- Clearing the count and disabling the watchdog each need an exact command byte.
- Disabling only works after the enable bit has been cleared.

Output selection can move from reset to interrupt but never back. The only way back is a system reset or a watchdog reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_n` is released, the watchdog is already running in reset mode with time select 00. With `lf_sel`=0, `rst_o` first rises exactly 2^(25-SHIFT) ticks after release. Both outputs are low while `rst_n` is low.
- R2: A reset-mode expiry holds `rst_o` high for exactly 4 clocks. The control register then reloads enable=1, select=00, output=reset mode, and counting restarts from zero.
- R3: With `lf_sel`=0, the detection time is 2^(25-2*s-SHIFT) ticks, where s is the time select. The time select is control data bits [2:1].
- R4: With `lf_sel`=1, the detection time is 2^(17-2*s-SHIFT) ticks.
- R5: An expiry in interrupt mode gives a one-clock `irq_o` pulse and leaves `rst_o` low. The count restarts at zero, so the next pulse comes one full period later.
- R6: Control data bit 0 selects the output: 0 for interrupt, 1 for reset. Once it has been written 0, writing 1 does not bring reset mode back.
- R7: Writing 0x4E to the command register (`wr_addr`=1) restarts the count from zero.
- R8: Writing 0xB1 to the command register stops the watchdog only when the enable bit (control data bit 3) is already 0. Writing enable=0 by itself does not stop the count.
- R9: Writing the control register with bit 3 set restarts counting from zero. This applies both from the stopped state and while running.
- R10: Any command byte other than 0x4E and 0xB1 is ignored.
- R11: The count advances only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | Count enable from the prescaler |
| lf_sel | input | 1 | 1 selects the slow timebase table |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = command register |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request pulse |
| rst_o | output | 1 | Reset request |

## Verification
The hardest state to reach is the control-register reload that follows a watchdog reset. No reset-mode expiry happens until the full reset-value period has elapsed, and the output select can only be restored by a reset.

The bench waits out the complete default period straight after reset release. It times the 4-clock request. It then switches to the slow timebase, so the reloaded select value shows up as a short 2^(7) tick period that ends in a second reset request.

The disable path is the second hard case: it needs the enable bit cleared before the key is written. The bench writes the key both with the enable bit set and after clearing it, and observes the expiry in each state.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       lf_sel,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq_o,
  output logic       rst_o
);
  localparam int HI_EXP = 25 - SHIFT;
  localparam int LO_EXP = 17 - SHIFT;
  localparam int CW = HI_EXP + 1;
  localparam logic [CW-1:0] ONE = 1;
  localparam logic [7:0] KEY_CLEAR = 8'h4E;
  localparam logic [7:0] KEY_OFF = 8'hB1;

  logic          en_bit, rst_mode, run, irq_q;
  logic [1:0]    tsel;
  logic [2:0]    hold;
  logic [CW-1:0] cnt;
  logic [5:0]    shamt;
  logic [CW-1:0] last;

  wire holding   = hold != 3'd0;
  wire ctl_wr    = wr_en & ~wr_addr & ~holding;
  wire key_wr    = wr_en & wr_addr & ~holding;
  wire do_clear  = key_wr & (wr_data == KEY_CLEAR);
  wire do_off    = key_wr & (wr_data == KEY_OFF) & ~en_bit;
  wire do_start  = ctl_wr & wr_data[3];
  wire zero_cnt  = do_clear | do_off | do_start;

  assign shamt = (lf_sel ? 6'(LO_EXP) : 6'(HI_EXP)) - 6'({tsel, 1'b0});
  assign last  = (ONE << shamt) - ONE;

  wire expire = run & tick & ~holding & ~zero_cnt & (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit   <= 1'b1;
      tsel     <= 2'b00;
      rst_mode <= 1'b1;
      run      <= 1'b1;
      cnt      <= '0;
      hold     <= 3'd0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= expire & ~rst_mode;
      if (holding) begin
        hold <= hold - 3'd1;
        if (hold == 3'd1) begin
          en_bit   <= 1'b1;
          tsel     <= 2'b00;
          rst_mode <= 1'b1;
          run      <= 1'b1;
          cnt      <= '0;
        end
      end else begin
        if (ctl_wr) begin
          en_bit   <= wr_data[3];
          tsel     <= wr_data[2:1];
          rst_mode <= rst_mode & wr_data[0];
        end
        if (do_start) run <= 1'b1;
        if (do_off)   run <= 1'b0;
        if (zero_cnt || expire) cnt <= '0;
        else if (run && tick)   cnt <= cnt + ONE;
        if (expire && rst_mode) hold <= 3'd4;
      end
    end
  end

  assign irq_o = irq_q;
  assign rst_o = holding;

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_o));
  assert_rst_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o && hold > 3'd1) |=> rst_o);
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (run && en_bit && rst_mode && tsel == 2'b00 && cnt == '0));
  assert_oneway_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_mode && !$past(rst_mode)) |-> $past(hold == 3'd1));
  assert_disable_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(wr_en && wr_addr && wr_data == KEY_OFF && !en_bit));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= last || $past(lf_sel) != lf_sel || $past(tsel) != tsel);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int SH = 10;
  logic clk = 0, rst_n = 0, tick = 1, lf_sel = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic irq_o, rst_o;
  int cyc = 0, checks = 0, errors = 0;

  keyed_watchdog #(.SHIFT(SH)) uut (.clk(clk), .rst_n(rst_n), .tick(tick), .lf_sel(lf_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_o(irq_o), .rst_o(rst_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic ei, input logic er);
    checks++;
    if (irq_o !== ei || rst_o !== er) begin
      errors++;
      $display("FAIL %s at cycle %0d: irq=%b rst=%b expected irq=%b rst=%b",
               tag, cyc, irq_o, rst_o, ei, er);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expiry(input string tag, input int p, input int t0, input logic rmode);
    wait_until(t0 + p - 1);
    chk(tag, 1'b0, 1'b0);
    @(negedge clk);
    if (rmode) chk(tag, 1'b0, 1'b1); else chk(tag, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 1'b0, 1'b0);
    rst_n = 1; t0 = cyc;
    expiry("R1", 1 << (25 - SH), t0, 1'b1);
    for (int i = 1; i < 4; i++) begin @(negedge clk); chk("R2 hold", 1'b0, 1'b1); end
    @(negedge clk); chk("R2 release", 1'b0, 1'b0);
    lf_sel = 1; t0 = cyc;
    expiry("R2 reload", 1 << (17 - SH), t0, 1'b1);
    wait_until(cyc + 4);
    // interrupt mode, slow table select 11
    wr(0, 8'h0E); t0 = cyc;
    expiry("R5", 2, t0, 1'b0);
    @(negedge clk); chk("R5 pulse end", 1'b0, 1'b0);
    expiry("R5 restart", 2, t0 + 2, 1'b0);
    wr(0, 8'h0F); t0 = cyc;
    expiry("R6 one-way", 2, t0, 1'b0);
    for (int s = 0; s < 4; s++) begin
      wr(0, 8'(8 | (s << 1))); t0 = cyc;
      expiry("R4 slow table", 1 << (17 - 2*s - SH), t0, 1'b0);
    end
    lf_sel = 0;
    for (int s = 0; s < 4; s++) begin
      wr(0, 8'(8 | (s << 1))); t0 = cyc;
      expiry("R3 fast table", 1 << (25 - 2*s - SH), t0, 1'b0);
    end
    begin
      int t1;
      wr(0, 8'h0E); t0 = cyc;
      wait_until(t0 + 300);
      wr(1, 8'h4E); t1 = cyc;
      wait_until(t0 + 512); chk("R7 no early expiry", 1'b0, 1'b0);
      expiry("R7 clear", 512, t1, 1'b0);
    end
    wr(0, 8'h0C); t0 = cyc;
    for (int c = 0; c < 256; c++)
      if (c != 8'h4E && c != 8'hB1) wr(1, 8'(c));
    expiry("R10 junk codes", 2048, t0, 1'b0);
    wr(0, 8'h0C); t0 = cyc;
    wr(1, 8'hB1);
    expiry("R8 key with enable set", 2048, t0, 1'b0);
    wr(0, 8'h04);
    expiry("R8 enable clear only", 2048, t0 + 2048, 1'b0);
    wr(1, 8'hB1);
    begin
      int seen = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (irq_o || rst_o) seen++;
      end
      checks++;
      if (seen != 0) begin
        errors++;
        $display("FAIL R8 disabled: %0d requests seen, expected 0", seen);
      end
    end
    wr(0, 8'h0C); t0 = cyc;
    expiry("R9 start from stop", 2048, t0, 1'b0);
    wait_until(cyc + 1000);
    wr(0, 8'h0C); t0 = cyc;
    expiry("R9 restart while running", 2048, t0, 1'b0);
    begin
      int t1;
      tick = 0;
      wr(0, 8'h0E); t0 = cyc;
      wait_until(t0 + 600);
      chk("R11 no tick", 1'b0, 1'b0);
      tick = 1; t1 = cyc;
      expiry("R11 tick", 512, t1, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule